// File: doc/BRIEF.md
# AXI Address Latency and Data Bandwidth Monitor

This block is a passive observer placed on one AXI master port. It never drives the bus. It watches the address channel and the two data channels. From these it measures how long each address request waits between first asserting VALID and being accepted. It also measures how many cycles carry data. Both measurements are gathered over back-to-back windows of a fixed number of cycles.

A free-running 32-bit cycle counter supplies the timestamps. When an address request first asserts VALID, the counter value is stored. When the handshake completes, the difference is taken as the latency. At the end of every window the monitor emits one record on a valid/ready output. The record holds the window's latency minimum, maximum and sum, the number of address tenures, the number of data cycles, the utilisation in whole percent, and the initiator and target bank of the last accepted address. A downstream collector drains the records. If the collector falls a full window behind, a sticky flag is raised.

Top module: `axi_perf_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rec_valid` and `ovf_flag` are 0.
- R2: The latency of an address tenure is the number of cycles from the first cycle with `mon_avalid` high to the cycle in which `mon_avalid` and `mon_aready` are both high. A handshake in the first VALID cycle has latency 0. If VALID drops without a handshake, the tenure is abandoned.
- R3: Windows are `WIN_CYCLES` cycles long. The first window starts in the first cycle after reset. A window ends at the edge that closes cycle k·`WIN_CYCLES`−1. Events in the boundary cycle k·`WIN_CYCLES` belong to the new window. A record becomes valid in the cycle after the boundary cycle.
- R4: `rec_beats` counts the cycles of the window with a read data handshake or a write data handshake. A cycle with both counts once. `rec_pct` is floor(`rec_beats`·100/`WIN_CYCLES`).
- R5: `rec_tenures` counts the address handshakes of the window. `rec_lat_min` and `rec_lat_max` are the smallest and largest latency among them. With no handshake, min reads all ones, and max and sum read 0.
- R6: A latency above 2^`LAT_W`−1 is reported as 2^`LAT_W`−1. `rec_lat_sum` sticks at 2^`SUM_W`−1 instead of wrapping.
- R7: `rec_id` is the `mon_aid` of the window's last address handshake. `rec_bank` is bits [`BANK_LSB`+`BANK_W`−1:`BANK_LSB`] of that handshake's `mon_aaddr`. Both read 0 when the window had no handshake.
- R8: While `rec_valid` is high and `rec_ready` is low, the record and `rec_valid` hold steady. After a handshake, `rec_valid` falls in the next cycle unless a boundary loads a new record in the same cycle.
- R9: If a record is still waiting unaccepted in a boundary cycle, it is kept and the new window's record is dropped. `ovf_flag` then goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_aid | input | ID_W | Address channel ID (initiator number) |
| mon_aaddr | input | ADDR_W | Address channel address |
| mon_avalid | input | 1 | Address VALID |
| mon_aready | input | 1 | Address READY |
| mon_rvalid | input | 1 | Read data VALID |
| mon_rready | input | 1 | Read data READY |
| mon_wvalid | input | 1 | Write data VALID |
| mon_wready | input | 1 | Write data READY |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Collector accepts record |
| rec_id | output | ID_W | Initiator of last address in window |
| rec_bank | output | BANK_W | Target bank of last address in window |
| rec_beats | output | $clog2(WIN_CYCLES+1) | Data cycles in window |
| rec_pct | output | 7 | Data utilisation in percent |
| rec_tenures | output | $clog2(WIN_CYCLES+1) | Address tenures in window |
| rec_lat_min | output | LAT_W | Smallest address latency |
| rec_lat_max | output | LAT_W | Largest address latency |
| rec_lat_sum | output | SUM_W | Saturating sum of address latencies |
| ovf_flag | output | 1 | Sticky record-overflow flag |

## Verification
Some properties are checked on every cycle. A pending record holds steady, and the overflow flag is sticky and set when a boundary meets an unaccepted record. Other checks cover latency: a same-cycle handshake gives 0, a waiting tenure's latency never falls, and the window sum never shrinks between boundaries. Within any record, min never exceeds max, and the beat count stays within the window length. Only the bench's scenarios can show that each field carries the right number. That covers the exact window alignment and the boundary-cycle ownership of events, clamping at the latency and sum limits, the empty-window encodings, the percentage rounding, the last-address ID and bank fields, and recovery after a second reset.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
   localparam int STAMP_W = 32;
   localparam int PCT_W   = 7;
   typedef logic [STAMP_W-1:0] stamp_t;
   typedef logic [PCT_W-1:0]   pct_t;
endpackage

// File: rtl/perf_stamp_timer.sv
module perf_stamp_timer
   import perf_mon_pkg::*;
#(
   parameter int LAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stamp_t           now,
   input  logic             vld,
   input  logic             rdy,
   output logic             hs,
   output logic [LAT_W-1:0] lat
);
   localparam logic [LAT_W-1:0] LAT_MAX = '1;

   logic   busy;
   stamp_t start;
   stamp_t diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         start <= '0;
      end else if (vld && rdy) begin
         busy <= 1'b0;
      end else if (vld && !busy) begin
         busy  <= 1'b1;
         start <= now;
      end else if (!vld) begin
         busy <= 1'b0;
      end
   end

   assign hs   = vld && rdy;
   assign diff = busy ? (now - start) : '0;
   assign lat  = (diff > STAMP_W'(LAT_MAX)) ? LAT_MAX : diff[LAT_W-1:0];

   // R2
   zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && rdy && !$past(vld)) |-> (lat == '0));

   // R2
   lat_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !rdy) |=> (!vld || lat >= $past(lat)));
endmodule

// File: rtl/perf_window_acc.sv
module perf_window_acc #(
   parameter int WIN_CYCLES = 500,
   parameter int LAT_W      = 16,
   parameter int SUM_W      = 24,
   parameter int ID_W       = 4,
   parameter int BANK_W     = 3,
   parameter bit SUM_SAT    = 1'b1,
   localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_end,
   input  logic              a_hs,
   input  logic [LAT_W-1:0]  a_lat,
   input  logic [ID_W-1:0]   a_id,
   input  logic [BANK_W-1:0] a_bank,
   input  logic              d_hs,
   output logic [CNT_W-1:0]  acc_beats,
   output logic [CNT_W-1:0]  acc_tenures,
   output logic [LAT_W-1:0]  acc_min,
   output logic [LAT_W-1:0]  acc_max,
   output logic [SUM_W-1:0]  acc_sum,
   output logic [ID_W-1:0]   acc_id,
   output logic [BANK_W-1:0] acc_bank
);
   logic [SUM_W:0]   sum_ext;
   logic [SUM_W-1:0] sum_next;

   assign sum_ext = {1'b0, acc_sum} + (SUM_W+1)'(a_lat);

   generate
      if (SUM_SAT) begin : g_sum_sat
         assign sum_next = sum_ext[SUM_W] ? '1 : sum_ext[SUM_W-1:0];
      end else begin : g_sum_wrap
         assign sum_next = sum_ext[SUM_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_beats   <= '0;
         acc_tenures <= '0;
         acc_min     <= '1;
         acc_max     <= '0;
         acc_sum     <= '0;
         acc_id      <= '0;
         acc_bank    <= '0;
      end else if (win_end) begin
         acc_beats   <= CNT_W'(d_hs);
         acc_tenures <= CNT_W'(a_hs);
         acc_min     <= a_hs ? a_lat : '1;
         acc_max     <= a_hs ? a_lat : '0;
         acc_sum     <= a_hs ? SUM_W'(a_lat) : '0;
         acc_id      <= a_hs ? a_id : '0;
         acc_bank    <= a_hs ? a_bank : '0;
      end else begin
         acc_beats <= acc_beats + CNT_W'(d_hs);
         if (a_hs) begin
            acc_tenures <= acc_tenures + 1'b1;
            if (a_lat < acc_min) acc_min <= a_lat;
            if (a_lat > acc_max) acc_max <= a_lat;
            acc_sum  <= sum_next;
            acc_id   <= a_id;
            acc_bank <= a_bank;
         end
      end
   end

   // R4
   beats_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_beats <= CNT_W'(WIN_CYCLES));

   // R6
   sum_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SUM_SAT && !win_end) |=> (acc_sum >= $past(acc_sum)));
endmodule

// File: rtl/perf_rec_out.sv
module perf_rec_out
   import perf_mon_pkg::*;
#(
   parameter int WIN_CYCLES = 500,
   parameter int LAT_W      = 16,
   parameter int SUM_W      = 24,
   parameter int ID_W       = 4,
   parameter int BANK_W     = 3,
   parameter bit PCT_EN     = 1'b1,
   localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_end,
   input  logic [CNT_W-1:0]  acc_beats,
   input  logic [CNT_W-1:0]  acc_tenures,
   input  logic [LAT_W-1:0]  acc_min,
   input  logic [LAT_W-1:0]  acc_max,
   input  logic [SUM_W-1:0]  acc_sum,
   input  logic [ID_W-1:0]   acc_id,
   input  logic [BANK_W-1:0] acc_bank,
   input  logic              rec_ready,
   output logic              rec_valid,
   output logic [ID_W-1:0]   rec_id,
   output logic [BANK_W-1:0] rec_bank,
   output logic [CNT_W-1:0]  rec_beats,
   output pct_t              rec_pct,
   output logic [CNT_W-1:0]  rec_tenures,
   output logic [LAT_W-1:0]  rec_lat_min,
   output logic [LAT_W-1:0]  rec_lat_max,
   output logic [SUM_W-1:0]  rec_lat_sum,
   output logic              ovf_flag
);
   pct_t pct_now;

   generate
      if (PCT_EN) begin : g_pct
         assign pct_now = PCT_W'((32'(acc_beats) * 32'd100) / 32'(WIN_CYCLES));
      end else begin : g_no_pct
         assign pct_now = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid   <= 1'b0;
         ovf_flag    <= 1'b0;
         rec_id      <= '0;
         rec_bank    <= '0;
         rec_beats   <= '0;
         rec_pct     <= '0;
         rec_tenures <= '0;
         rec_lat_min <= '0;
         rec_lat_max <= '0;
         rec_lat_sum <= '0;
      end else if (win_end) begin
         if (rec_valid && !rec_ready) begin
            ovf_flag <= 1'b1;
         end else begin
            rec_valid   <= 1'b1;
            rec_id      <= acc_id;
            rec_bank    <= acc_bank;
            rec_beats   <= acc_beats;
            rec_pct     <= pct_now;
            rec_tenures <= acc_tenures;
            rec_lat_min <= acc_min;
            rec_lat_max <= acc_max;
            rec_lat_sum <= acc_sum;
         end
      end else if (rec_valid && rec_ready) begin
         rec_valid <= 1'b0;
      end
   end

   // R8
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_beats) && $stable(rec_lat_sum)
                                     && $stable(rec_tenures) && $stable(rec_id)));

   // R9
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && rec_valid && !rec_ready) |=> ovf_flag);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   // R5
   min_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_tenures != '0) |-> (rec_lat_min <= rec_lat_max));

   // R5
   empty_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_tenures == '0) |-> (rec_lat_sum == '0 && rec_lat_max == '0));
endmodule

// File: rtl/axi_perf_monitor.sv
module axi_perf_monitor
   import perf_mon_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ID_W       = 4,
   parameter int BANK_LSB   = 12,
   parameter int BANK_W     = 3,
   parameter int WIN_CYCLES = 500,
   parameter int LAT_W      = 16,
   parameter int SUM_W      = 24,
   parameter bit SUM_SAT    = 1'b1,
   parameter bit PCT_EN     = 1'b1,
   localparam int CNT_W     = $clog2(WIN_CYCLES + 1),
   localparam int WC_W      = $clog2(WIN_CYCLES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   mon_aid,
   input  logic [ADDR_W-1:0] mon_aaddr,
   input  logic              mon_avalid,
   input  logic              mon_aready,
   input  logic              mon_rvalid,
   input  logic              mon_rready,
   input  logic              mon_wvalid,
   input  logic              mon_wready,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [ID_W-1:0]   rec_id,
   output logic [BANK_W-1:0] rec_bank,
   output logic [CNT_W-1:0]  rec_beats,
   output logic [6:0]        rec_pct,
   output logic [CNT_W-1:0]  rec_tenures,
   output logic [LAT_W-1:0]  rec_lat_min,
   output logic [LAT_W-1:0]  rec_lat_max,
   output logic [SUM_W-1:0]  rec_lat_sum,
   output logic              ovf_flag
);
   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("WIN_CYCLES must be at least 2");
      end
      if (SUM_W < LAT_W) begin : g_bad_sum
         $error("SUM_W must not be narrower than LAT_W");
      end
      if (LAT_W > 31 || LAT_W < 1) begin : g_bad_lat
         $error("LAT_W must lie in 1..31");
      end
      if (BANK_LSB + BANK_W > ADDR_W) begin : g_bad_bank
         $error("bank field exceeds address width");
      end
   endgenerate

   stamp_t            now;
   logic [WC_W-1:0]   wcnt;
   logic              win_end;
   logic              a_hs;
   logic              d_hs;
   logic [LAT_W-1:0]  a_lat;
   logic [BANK_W-1:0] a_bank;

   logic [CNT_W-1:0]  acc_beats, acc_tenures;
   logic [LAT_W-1:0]  acc_min, acc_max;
   logic [SUM_W-1:0]  acc_sum;
   logic [ID_W-1:0]   acc_id;
   logic [BANK_W-1:0] acc_bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now     <= '0;
         wcnt    <= '0;
         win_end <= 1'b0;
      end else begin
         now     <= now + 1'b1;
         win_end <= (wcnt == WC_W'(WIN_CYCLES - 1));
         wcnt    <= (wcnt == WC_W'(WIN_CYCLES - 1)) ? '0 : wcnt + 1'b1;
      end
   end

   assign d_hs   = (mon_rvalid && mon_rready) || (mon_wvalid && mon_wready);
   assign a_bank = BANK_W'(mon_aaddr >> BANK_LSB);

   perf_stamp_timer #(.LAT_W(LAT_W)) addr_timer_i (
      .clk (clk),
      .rst_n (rst_n),
      .now (now),
      .vld (mon_avalid),
      .rdy (mon_aready),
      .hs  (a_hs),
      .lat (a_lat)
   );

   perf_window_acc #(
      .WIN_CYCLES(WIN_CYCLES), .LAT_W(LAT_W), .SUM_W(SUM_W),
      .ID_W(ID_W), .BANK_W(BANK_W), .SUM_SAT(SUM_SAT)
   ) acc_i (
      .clk (clk),
      .rst_n (rst_n),
      .win_end (win_end),
      .a_hs (a_hs),
      .a_lat (a_lat),
      .a_id (mon_aid),
      .a_bank (a_bank),
      .d_hs (d_hs),
      .acc_beats (acc_beats),
      .acc_tenures (acc_tenures),
      .acc_min (acc_min),
      .acc_max (acc_max),
      .acc_sum (acc_sum),
      .acc_id (acc_id),
      .acc_bank (acc_bank)
   );

   perf_rec_out #(
      .WIN_CYCLES(WIN_CYCLES), .LAT_W(LAT_W), .SUM_W(SUM_W),
      .ID_W(ID_W), .BANK_W(BANK_W), .PCT_EN(PCT_EN)
   ) out_i (
      .clk (clk),
      .rst_n (rst_n),
      .win_end (win_end),
      .acc_beats (acc_beats),
      .acc_tenures (acc_tenures),
      .acc_min (acc_min),
      .acc_max (acc_max),
      .acc_sum (acc_sum),
      .acc_id (acc_id),
      .acc_bank (acc_bank),
      .rec_ready (rec_ready),
      .rec_valid (rec_valid),
      .rec_id (rec_id),
      .rec_bank (rec_bank),
      .rec_beats (rec_beats),
      .rec_pct (rec_pct),
      .rec_tenures (rec_tenures),
      .rec_lat_min (rec_lat_min),
      .rec_lat_max (rec_lat_max),
      .rec_lat_sum (rec_lat_sum),
      .ovf_flag (ovf_flag)
   );

   // R3
   win_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> !win_end);
endmodule

// File: tb/axi_perf_monitor_tb.sv
`timescale 1ns/1ps
module axi_perf_monitor_tb_top;
   localparam int WIN    = 50;
   localparam int LATW   = 4;
   localparam int SUMW   = 6;
   localparam int LATMAX = 15;
   localparam int SUMMAX = 63;
   localparam int CNTW   = $clog2(WIN + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] aid = '0;
   logic [7:0] aaddr = '0;
   logic av = 1'b0, ar = 1'b0, rv = 1'b0, rr = 1'b0, wv = 1'b0, wr = 1'b0;
   logic rec_ready = 1'b0;
   logic rec_valid, ovf_flag;
   logic [2:0] rec_id;
   logic [1:0] rec_bank;
   logic [CNTW-1:0] rec_beats, rec_tenures;
   logic [6:0] rec_pct;
   logic [LATW-1:0] rec_lat_min, rec_lat_max;
   logic [SUMW-1:0] rec_lat_sum;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   axi_perf_monitor #(
      .ADDR_W(8), .ID_W(3), .BANK_LSB(4), .BANK_W(2), .WIN_CYCLES(WIN),
      .LAT_W(LATW), .SUM_W(SUMW), .SUM_SAT(1'b1), .PCT_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mon_aid(aid), .mon_aaddr(aaddr),
      .mon_avalid(av), .mon_aready(ar), .mon_rvalid(rv), .mon_rready(rr),
      .mon_wvalid(wv), .mon_wready(wr), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_id(rec_id), .rec_bank(rec_bank), .rec_beats(rec_beats), .rec_pct(rec_pct),
      .rec_tenures(rec_tenures), .rec_lat_min(rec_lat_min), .rec_lat_max(rec_lat_max),
      .rec_lat_sum(rec_lat_sum), .ovf_flag(ovf_flag)
   );

   // reference model state
   int c, vstart;
   int m_beats, m_n, m_min, m_max, m_sum, m_id, m_bank;
   int e_valid, e_beats, e_pct, e_n, e_min, e_max, e_sum, e_id, e_bank, e_ovf;

   task automatic model_reset();
      c = 0; vstart = -1;
      m_beats = 0; m_n = 0; m_min = LATMAX; m_max = 0; m_sum = 0; m_id = 0; m_bank = 0;
      e_valid = 0; e_beats = 0; e_pct = 0; e_n = 0; e_min = 0; e_max = 0;
      e_sum = 0; e_id = 0; e_bank = 0; e_ovf = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         int lat;
         bit ahs, dhs;
         lat = 0;
         ahs = av && ar;
         dhs = (rv && rr) || (wv && wr);
         if (av && vstart < 0) vstart = c;
         if (ahs) begin
            lat = c - vstart;
            if (lat > LATMAX) lat = LATMAX;
            vstart = -1;
         end else if (!av) begin
            vstart = -1;
         end
         if (e_valid != 0 && rec_ready) e_valid = 0;
         if (c > 0 && c % WIN == 0) begin
            if (e_valid != 0) begin
               e_ovf = 1;
            end else begin
               e_valid = 1; e_beats = m_beats; e_pct = m_beats * 100 / WIN;
               e_n = m_n; e_min = m_min; e_max = m_max; e_sum = m_sum;
               e_id = m_id; e_bank = m_bank;
            end
            m_beats = dhs ? 1 : 0;
            m_n = ahs ? 1 : 0;
            m_min = ahs ? lat : LATMAX;
            m_max = ahs ? lat : 0;
            m_sum = ahs ? lat : 0;
            m_id = ahs ? int'(aid) : 0;
            m_bank = ahs ? int'(aaddr[5:4]) : 0;
         end else begin
            if (dhs) m_beats++;
            if (ahs) begin
               m_n++;
               if (lat < m_min) m_min = lat;
               if (lat > m_max) m_max = lat;
               m_sum = (m_sum + lat > SUMMAX) ? SUMMAX : m_sum + lat;
               m_id = int'(aid);
               m_bank = int'(aaddr[5:4]);
            end
         end
         c++;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R3/R8", "rec_valid", int'(rec_valid), e_valid);
      chk("R9", "ovf_flag", int'(ovf_flag), e_ovf);
      if (e_valid != 0 && rec_valid) begin
         chk("R4", "beats", int'(rec_beats), e_beats);
         chk("R4", "pct", int'(rec_pct), e_pct);
         chk("R5", "tenures", int'(rec_tenures), e_n);
         chk("R5", "lat_min", int'(rec_lat_min), e_min);
         chk("R2", "lat_max", int'(rec_lat_max), e_max);
         chk("R6", "lat_sum", int'(rec_lat_sum), e_sum);
         chk("R7", "id", int'(rec_id), e_id);
         chk("R7", "bank", int'(rec_bank), e_bank);
      end
   endtask

   function automatic logic pick(input int pct);
      return ($urandom % 100) < pct;
   endfunction

   // vp: address VALID chance, rp: address READY chance, dp: data chance, qp: record READY chance
   task automatic run(input int n, input int vp, input int rp, input int dp, input int qp);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         if (av && ar) av = 1'b0;
         if (!av) begin
            av = pick(vp);
            aaddr = 8'($urandom);
            aid = 3'($urandom);
         end
         ar = pick(rp);
         rv = pick(dp); rr = pick(dp); wv = pick(dp); wr = pick(dp);
         rec_ready = pick(qp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      av = 0; ar = 0; rv = 0; rr = 0; wv = 0; wr = 0; rec_ready = 0;
      repeat (3) @(negedge clk);
      // R1: outputs idle while in reset
      chk("R1", "rec_valid in reset", int'(rec_valid), 0);
      chk("R1", "ovf_flag in reset", int'(ovf_flag), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      do_reset();
      run(300, 50, 50, 60, 100);   // mixed traffic, collector always ready
      run(200, 70, 100, 0, 50);    // zero-latency handshakes, idle data (R2, R4 empty)
      run(200, 5, 0, 80, 100);     // almost no addresses accepted (R5 empty window)
      run(300, 80, 10, 90, 100);   // long waits, clamped latency and sum (R6)
      run(200, 60, 40, 50, 0);     // collector stalls: overflow (R9)
      run(100, 60, 40, 50, 100);
      do_reset();
      run(400, 60, 60, 70, 40);    // random back-pressure after second reset (R1, R8)
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule